// File: doc/BRIEF.md
# Prescaled 8-bit backlight PWM generator

This block produces one pulse-width-modulated output for dimming a display backlight. A period is 256 steps of an 8-bit counter, and the counter advances once every 2^N ticks of the chosen source clock. N is a 3-bit prescaler select. The output is active while the counter is below an 8-bit compare value. A polarity bit picks whether "active" means high or low. The longest on time is therefore 255 of 256 steps, so the output is never on for a whole period.

Software sets the block up through a plain register port. A general register selects the source clock. Both sources reach the block as one-cycle tick enables in the block's own clock domain. A channel register holds the compare value, the polarity and the prescaler select. Separate write-one strobes start and stop the channel. A status register reports whether the channel is really running, so software polls that bit after each strobe.

Changes to the channel setup while the channel runs wait for the end of the current period. A stop also waits for the end of the current period, so no pulse is cut short. An out-of-range prescaler select is clamped to the nearest legal value and sets a sticky error flag.

Top module: `bklt_pwm_top`

## Requirements
- R1: After reset, the following hold. The status register (address 4) reads 0 in both bit 0 and bit 1. The output is low. The channel register (address 1) reads 0x0010, which means compare 0, polarity 1 and select 0. The general register (address 0) reads 0.
- R2: The channel register holds the compare value in bits 15:8, the polarity in bit 4 and the prescaler select in bits 2:0. With select S from 0 to 6, one output period lasts 256·2^S source ticks. The active time in each period is compare·2^S ticks, and each period has exactly one rising edge of the active level.
- R3: A compare value of 0 keeps the output inactive for the whole period. A compare value of 255 gives 255/256 duty, so one step of inactive level always remains and the output is never fully on.
- R4: With polarity bit 4 set to 1, the output is high while the counter is below the compare value. With the bit set to 0, the output is the inverse of that.
- R5: Writing bit 0 to address 2 starts the channel. Writing bit 0 to address 3 stops it, but only when the counter wraps from 255 to 0. Status bit 0 at address 4 shows the running state, and it stays 1 until that wrap.
- R6: General register bit 0 selects the PWM source tick: 1 selects sys_tick and 0 selects slow_tick.
- R7: When the parameter NO_DIV1 is 1, a prescaler select of 0 is handled as 1, and writing it sets the error flag.
- R8: A prescaler select of 7 is handled as 6 and sets status bit 1. That error bit stays set until reset, even after later valid writes.
- R9: While the channel runs, a new compare value, polarity or select takes effect only at the next wrap from 255 to 0. While the channel is stopped, a new setting takes effect at once.
- R10: While the channel is stopped, the output sits at its inactive level, which is the inverse of the polarity bit, and the counter and prescaler are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle tick from the slow source |
| sys_tick | input | 1 | One-cycle tick from the system source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data, valid one cycle after rd_addr |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Assertions check the following on every cycle:
- the channel stops only at a counter wrap;
- the latched setting never moves in the middle of a period;
- a stopped channel holds its counter at zero and drives the inactive level;
- the prescaler count stays within its limit;
- a clamped select never exceeds the legal range, and a bad write always raises the error flag.

Other behaviour can only be shown by the bench's scenarios. These are the actual high-time and rising-edge counts over whole periods for each compare value, polarity, select and clock source. They also cover the late effect of a compare write made in the middle of a period, and the delay before status drops after a stop request.

// File: rtl/bklt_pkg.sv
package bklt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int PS_W   = 3;

  localparam logic [ADDR_W-1:0] A_GEN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CHAN = 3'd1;
  localparam logic [ADDR_W-1:0] A_ON   = 3'd2;
  localparam logic [ADDR_W-1:0] A_OFF  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int CMP_LSB = 8;
  localparam int POL_BIT = 4;

  localparam logic [DATA_W-1:0] CHAN_MASK = 16'hFF17;
  localparam logic [DATA_W-1:0] CHAN_RST  = 16'h0010;

  typedef struct packed {
    logic [CNT_W-1:0] cmp;
    logic             pol;
    logic [PS_W-1:0]  ps;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RST = '{cmp: '0, pol: 1'b1, ps: '0};
endpackage

// File: rtl/bklt_regs.sv
module bklt_regs
  import bklt_pkg::*;
#(
  parameter int PS_MAX  = 6,
  parameter bit NO_DIV1 = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              running,
  output logic [DATA_W-1:0] rd_data,
  output chan_cfg_t         cfg,
  output logic              clk_sel,
  output logic              on_stb,
  output logic              off_stb
);
  localparam logic [PS_W-1:0] PS_TOP = PS_W'(PS_MAX);

  logic [DATA_W-1:0] chan_raw;
  logic              sel_q;
  logic              err_q;
  logic [PS_W-1:0]   wr_ps;
  logic              wr_chan;
  logic              wr_bad;

  function automatic logic [PS_W-1:0] fix_ps(input logic [PS_W-1:0] p);
    if (p > PS_TOP) return PS_TOP;
    if (NO_DIV1 && (p == '0)) return PS_W'(1);
    return p;
  endfunction

  assign wr_ps   = wr_data[PS_W-1:0];
  assign wr_chan = wr_en && (wr_addr == A_CHAN);
  assign wr_bad  = (wr_ps > PS_TOP) || (NO_DIV1 && (wr_ps == '0));
  assign on_stb  = wr_en && (wr_addr == A_ON) && wr_data[0];
  assign off_stb = wr_en && (wr_addr == A_OFF) && wr_data[0];

  assign cfg.cmp = chan_raw[CMP_LSB +: CNT_W];
  assign cfg.pol = chan_raw[POL_BIT];
  assign cfg.ps  = fix_ps(chan_raw[PS_W-1:0]);
  assign clk_sel = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_raw <= CHAN_RST;
      sel_q    <= 1'b0;
      err_q    <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_chan) begin
        chan_raw <= wr_data & CHAN_MASK;
        if (wr_bad) err_q <= 1'b1;
      end
      if (wr_en && (wr_addr == A_GEN)) sel_q <= wr_data[0];
      case (rd_addr)
        A_GEN:   rd_data <= {{(DATA_W-1){1'b0}}, sel_q};
        A_CHAN:  rd_data <= chan_raw;
        A_STAT:  rd_data <= {{(DATA_W-2){1'b0}}, err_q, running};
        default: rd_data <= '0;
      endcase
    end
  end

  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (rst)
    (wr_chan && (wr_ps > PS_TOP)) |=> err_q); // R8
  AST_PS_CLAMP: assert property (@(posedge clk) disable iff (rst)
    cfg.ps <= PS_TOP); // R8
  AST_NO_DIV1: assert property (@(posedge clk) disable iff (rst)
    !(NO_DIV1 && (cfg.ps == '0))); // R7
endmodule

// File: rtl/bklt_prescale.sv
module bklt_prescale
  import bklt_pkg::*;
#(
  parameter int PS_MAX = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            src_tick,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int PRE_W = (PS_MAX > 0) ? PS_MAX : 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) lim[i] = (i < int'(ps));
  end

  assign tick = run && src_tick && (pre == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) pre <= '0;
    else if (src_tick) pre <= (pre == lim) ? '0 : pre + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
    pre <= lim); // R2
endmodule

// File: rtl/bklt_core.sv
module bklt_core
  import bklt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      on_stb,
  input  logic      off_stb,
  input  logic      tick,
  input  chan_cfg_t cfg_live,
  output chan_cfg_t sh,
  output logic      running,
  output logic      pwm_out
);
  logic             want;
  logic [CNT_W-1:0] cnt;
  logic             boundary;
  logic             out_q;

  assign boundary = tick && (cnt == '1);
  assign pwm_out  = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      want    <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
      sh      <= CFG_RST;
      out_q   <= 1'b0;
    end else begin
      if (on_stb) want <= 1'b1;
      else if (off_stb) want <= 1'b0;
      if (!running) begin
        cnt <= '0;
        sh  <= cfg_live;
        if (want) running <= 1'b1;
      end else begin
        if (tick) cnt <= cnt + 1'b1;
        if (boundary) begin
          sh <= cfg_live;
          if (!want) running <= 1'b0;
        end
      end
      out_q <= running ? ((cnt < sh.cmp) == sh.pol) : !sh.pol;
    end
  end

  AST_STOP_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(boundary)); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && !boundary) |=> $stable(sh)); // R9
  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (rst)
    !running |-> (cnt == '0)); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !$past(running) |-> (out_q == !$past(sh.pol))); // R10
endmodule

// File: rtl/bklt_pwm_top.sv
module bklt_pwm_top
  import bklt_pkg::*;
#(
  parameter int PS_MAX  = 6,
  parameter bit NO_DIV1 = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              sys_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out
);
  chan_cfg_t cfg_live;
  chan_cfg_t sh;
  logic      clk_sel;
  logic      on_stb;
  logic      off_stb;
  logic      running;
  logic      src_tick;
  logic      tick;

  assign src_tick = clk_sel ? sys_tick : slow_tick;

  bklt_regs #(.PS_MAX(PS_MAX), .NO_DIV1(NO_DIV1)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .running(running), .rd_data(rd_data), .cfg(cfg_live),
    .clk_sel(clk_sel), .on_stb(on_stb), .off_stb(off_stb)
  );

  bklt_prescale #(.PS_MAX(PS_MAX)) u_pre (
    .clk(clk), .rst(rst), .run(running), .src_tick(src_tick), .ps(sh.ps), .tick(tick)
  );

  bklt_core u_core (
    .clk(clk), .rst(rst), .on_stb(on_stb), .off_stb(off_stb), .tick(tick),
    .cfg_live(cfg_live), .sh(sh), .running(running), .pwm_out(pwm_out)
  );
endmodule

// File: tb/sim_bklt_pwm_top.sv
`timescale 1ns/1ps
module sim_bklt_pwm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        sys_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd0, rd1;
  logic        out0, out1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bklt_pwm_top u0 (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .sys_tick(sys_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd0), .pwm_out(out0)
  );

  bklt_pwm_top #(.NO_DIV1(1'b1)) u1 (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .sys_tick(sys_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd1), .pwm_out(out1)
  );

  initial begin
    int sdiv;
    sdiv = 0;
    forever begin
      @(negedge clk);
      sdiv = (sdiv + 1) % 4;
      slow_tick = (sdiv == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d0, output logic [15:0] d1);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d0 = rd0; d1 = rd1;
  endtask

  task automatic poll(input bit want, input int limit, output int waited);
    logic [15:0] a, b;
    waited = 0;
    rd(3'd4, a, b);
    while (a[0] != want && waited < limit) begin
      rd(3'd4, a, b);
      waited++;
    end
  endtask

  task automatic measure(input int w, output int hi0, output int ri0,
                         output int hi1, output int ri1);
    logic p0, p1;
    hi0 = 0; ri0 = 0; hi1 = 0; ri1 = 0;
    @(negedge clk);
    p0 = out0; p1 = out1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (out0) hi0++;
      if (out1) hi1++;
      if (out0 && !p0) ri0++;
      if (out1 && !p1) ri1++;
      p0 = out0; p1 = out1;
    end
  endtask

  function automatic int exp_hi(int cmp, int pol, int ps, int w, int scale);
    int per;
    per = (256 << ps) * scale;
    return (w / per) * ((pol != 0) ? (cmp << ps) : ((256 - cmp) << ps)) * scale;
  endfunction

  function automatic int exp_ri(int cmp, int ps, int w, int scale);
    if (cmp == 0) return 0;
    return w / ((256 << ps) * scale);
  endfunction

  task automatic run_cfg(input int sel, input int cmp, input int pol, input int ps_raw,
                         input int settle);
    int wt;
    wr(3'd3, 16'h0001);
    poll(1'b0, 40000, wt);
    wr(3'd0, 16'(sel));
    wr(3'd1, 16'((cmp << 8) | (pol << 4) | ps_raw));
    wr(3'd2, 16'h0001);
    poll(1'b1, 100, wt);
    repeat (settle) @(negedge clk);
  endtask

  task automatic cfg_check(input int sel, input int cmp, input int pol, input int ps_raw,
                           input string req);
    int eff, scale, per, w, h0, r0, h1, r1;
    eff = (ps_raw > 6) ? 6 : ps_raw;
    scale = (sel != 0) ? 1 : 4;
    per = (256 << eff) * scale;
    w = (eff <= 2) ? 2 * per : per;
    run_cfg(sel, cmp, pol, ps_raw, (sel != 0) ? 0 : per);
    measure(w, h0, r0, h1, r1);
    check(h0 == exp_hi(cmp, pol, eff, w, scale), req, "active/high count", h0,
          exp_hi(cmp, pol, eff, w, scale));
    check(r0 == exp_ri((pol != 0) ? cmp : 256 - cmp, eff, w, scale) ||
          ((pol == 0) && (cmp == 0) && (r0 == 0)), req, "rising edges", r0,
          exp_ri((pol != 0) ? cmp : 256 - cmp, eff, w, scale));
  endtask

  task automatic wait_rise();
    logic p;
    int n;
    n = 0;
    @(negedge clk);
    p = out0;
    do begin
      @(negedge clk);
      n++;
      if (out0 && !p) break;
      p = out0;
    end while (n < 4000);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    int h0, r0, h1, r1, wt, seed_dummy;
    int rc, rp, rs;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state
    check(out0 == 1'b0, "R1", "output after reset", int'(out0), 0);
    rd(3'd4, a, b);
    check(a == 16'h0000, "R1", "status after reset", int'(a), 0);
    rd(3'd1, a, b);
    check(a == 16'h0010, "R1", "channel register after reset", int'(a), 16'h0010);
    rd(3'd0, a, b);
    check(a == 16'h0000, "R1", "general register after reset", int'(a), 0);

    // R2 and R7: select 0, compare 128; the NO_DIV1 copy runs at twice the period
    run_cfg(1, 128, 1, 0, 0);
    measure(512, h0, r0, h1, r1);
    check(h0 == 256, "R2", "select 0 high count", h0, 256);
    check(r0 == 2, "R2", "select 0 rising edges", r0, 2);
    check(h1 == 256, "R7", "no-div1 high count", h1, 256);
    check(r1 == 1, "R7", "no-div1 rising edges", r1, 1);
    rd(3'd4, a, b);
    check(b[1] == 1'b1, "R7", "no-div1 error flag", int'(b[1]), 1);
    check(a[1] == 1'b0, "R8", "error flag clear on valid select", int'(a[1]), 0);

    // R9: a compare write in mid-period waits for the wrap
    wait_rise();
    wr(3'd1, 16'h1010);
    repeat (60) @(negedge clk);
    check(out0 == 1'b1, "R9", "old compare kept in current period", int'(out0), 1);
    repeat (600) @(negedge clk);
    measure(512, h0, r0, h1, r1);
    check(h0 == 32, "R9", "new compare after wrap", h0, 32);

    // R5: stop takes effect only at the wrap
    wait_rise();
    wr(3'd3, 16'h0001);
    repeat (40) @(negedge clk);
    rd(3'd4, a, b);
    check(a[0] == 1'b1, "R5", "status still running before wrap", int'(a[0]), 1);
    poll(1'b0, 300, wt);
    check(wt < 300, "R5", "status drops within one period", wt, 299);
    repeat (3) @(negedge clk);
    check(out0 == 1'b0, "R10", "idle level with polarity 1", int'(out0), 0);

    // R3 and R4: directed compare and polarity corners
    for (int ps = 0; ps < 2; ps++) begin
      for (int pol = 0; pol < 2; pol++) begin
        cfg_check(1, 0, pol, ps, (pol != 0) ? "R3" : "R4");
        cfg_check(1, 1, pol, ps, (pol != 0) ? "R2" : "R4");
        cfg_check(1, 255, pol, ps, (pol != 0) ? "R3" : "R4");
      end
    end

    // R2 and R4: random compare, polarity and select with a fixed seed
    seed_dummy = $urandom(32'd2024);
    for (int t = 0; t < 6; t++) begin
      rc = $urandom % 256;
      rp = $urandom % 2;
      rs = $urandom % 3;
      cfg_check(1, rc, rp, rs, (rp != 0) ? "R2" : "R4");
    end

    // R2: select sweep
    for (int ps = 1; ps < 6; ps++) cfg_check(1, 128, 1, ps, "R2");

    // R6: slow source, four clocks per tick
    cfg_check(0, 64, 1, 0, "R6");

    // R10: stopped channel with polarity 0 drives high
    wr(3'd3, 16'h0001);
    poll(1'b0, 40000, wt);
    wr(3'd1, 16'h8000);
    repeat (4) @(negedge clk);
    check(out0 == 1'b1, "R10", "idle level with polarity 0", int'(out0), 1);
    rd(3'd1, a, b);
    check(a == 16'h8000, "R2", "channel register readback", int'(a), 16'h8000);

    // R8: select 7 clamped to 6, sticky error
    cfg_check(1, 128, 1, 7, "R8");
    rd(3'd4, a, b);
    check(a[1] == 1'b1, "R8", "error flag after select 7", int'(a[1]), 1);
    wr(3'd1, 16'h8013);
    rd(3'd4, a, b);
    check(a[1] == 1'b1, "R8", "error flag sticky", int'(a[1]), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule